// File: doc/BRIEF.md
# Peripheral Clock Gate Register Bank

This block holds the on/off state of up to 64 peripheral clock gates and produces one gated copy of the master clock for each peripheral. Each peripheral has a numeric id, and that id is its bit position in the register words. The ids are split into 32-bit banks. Each bank has three registers: a write-one-to-set register that turns gates on, a write-one-to-clear register that turns them off, and a status register that reports the current state.

Software turns on one or more peripherals with a single write of a one-hot or multi-bit mask, and turns them off the same way. It never needs a read-modify-write sequence. The two lowest ids are fixed on, so their gates cannot be switched off by a bus write. Each gate enable is retimed on the falling edge of the master clock. A gated clock therefore starts or stops only during the low phase and never produces a shortened pulse.

The bus is a simple synchronous register port. The address is a word address: bits [ADDR_W-1:2] select the bank and bits [1:0] select the register within it (0 = set, 1 = clear, 2 = status, 3 = reserved). With the default parameters, bank 0 (ids 0..31) sits at addresses 0..3 and bank 1 (ids 32..63) at addresses 4..7.

Top module: `pclk_gate_bank`

## Requirements
- R1: A write to a bank's set register (sub-address 0) turns on the gate of every id whose bit is 1 in the written word, where id = 32 * bank + bit.
- R2: A write to a bank's clear register (sub-address 1) turns off the gate of every id whose bit is 1 in the written word. The fixed-on ids are the only exception.
- R3: Bits written as 0 to a set or clear register leave the matching gates unchanged.
- R4: A read of a bank's status register (sub-address 2) returns that bank's gate states on `bus_rdata` in the cycle after the read request.
- R5: Ids 32..63 live in bank 1 (addresses 4..6), at bit position id - 32. Writes to one bank never alter the other bank.
- R6: Ids below FIXED_ON (ids 0 and 1 by default) always read as on. Writes to their set or clear bits have no effect.
- R7: After reset, every gate is off except the fixed-on ids. This holds both at power-up and for a reset applied during operation.
- R8: The set, clear and reserved addresses always read back as zero.
- R9: A write to a status address is ignored.
- R10: `gclk_out[n]` is high only while the master clock is high and gate n is on. It is low throughout every low phase of the master clock. A change of gate state reaches `gclk_out` at the first rising edge that follows the next falling edge.
- R11: `gate_en[n]` equals the current state of gate n, the same value that the status register reports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address: bank in the upper bits, register in bits [1:0] |
| bus_wdata | input | DATA_W | Write data, one bit per id in the bank |
| bus_rdata | output | DATA_W | Read data, registered, valid the cycle after a read |
| gate_en | output | NUM_IDS | Current gate state, one bit per id |
| gclk_out | output | NUM_IDS | Gated master clock, one per id |

## Verification
The set and clear registers are exercised with several kinds of mask:
- Multi-bit masks show that bits are set and cleared independently.
- All-ones masks check the full width of a bank and the protection of the fixed-on ids.
- All-zero masks show that a 0 bit has no effect.
- Masks with a single bit at the top and bottom of bank 1 confirm the id-to-bank mapping and that one bank cannot reach the other.

Reads of the set, clear and reserved addresses, and writes to a status address, separate the read-as-zero and write-ignored paths from the status path. Probing the gated clocks in the middle of the high phase and of the low phase confirms that only enabled ids pulse, and only while the master clock is high.

// File: rtl/pgb_pkg.sv
package pgb_pkg;
   // Register selector held in address bits [1:0] inside each bank
   typedef enum logic [1:0] {
      REG_SET = 2'd0,
      REG_CLR = 2'd1,
      REG_STA = 2'd2,
      REG_RSV = 2'd3
   } reg_kind_e;
endpackage

// File: rtl/pgb_regbank.sv
module pgb_regbank #(
   parameter int DATA_W   = 32,
   parameter int BASE_ID  = 0,
   parameter int FIXED_ON = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] set_mask,
   input  logic [DATA_W-1:0] clr_mask,
   output logic [DATA_W-1:0] state
);
   function automatic logic [DATA_W-1:0] build_fixed();
      logic [DATA_W-1:0] m;
      m = '0;
      for (int i = 0; i < DATA_W; i++)
         if (BASE_ID + i < FIXED_ON) m[i] = 1'b1;
      return m;
   endfunction

   localparam logic [DATA_W-1:0] FIXED_MASK = build_fixed();

   // Clear has priority over set; fixed ids are forced back on every cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= FIXED_MASK;
      else        state <= ((state | set_mask) & ~clr_mask) | FIXED_MASK;
   end
endmodule

// File: rtl/pgb_gate_cell.sv
module pgb_gate_cell #(
   parameter bit INIT_ON = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic gclk
);
   logic en_lo;

   // Enable is sampled on the falling edge, so it only moves while clk is low
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) en_lo <= INIT_ON;
      else        en_lo <= en;
   end

   assign gclk = clk & en_lo;
endmodule

// File: rtl/pgb_rd_mux.sv
module pgb_rd_mux import pgb_pkg::*; #(
   parameter int NUM_IDS = 64,
   parameter int DATA_W  = 32,
   parameter int BANK_FW = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_fire,
   input  logic [BANK_FW-1:0] rd_bank,
   input  reg_kind_e          rd_kind,
   input  logic [NUM_IDS-1:0] state_all,
   output logic [DATA_W-1:0]  rdata
);
   localparam int NUM_BANKS = NUM_IDS / DATA_W;

   logic [DATA_W-1:0] sel_word;

   // Only a status read of an existing bank returns data; all else is zero
   always_comb begin
      sel_word = '0;
      for (int b = 0; b < NUM_BANKS; b++)
         if (rd_bank == BANK_FW'(b) && rd_kind == REG_STA)
            sel_word = state_all[b*DATA_W +: DATA_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata <= '0;
      else if (rd_fire) rdata <= sel_word;
   end
endmodule

// File: rtl/pclk_gate_bank.sv
module pclk_gate_bank import pgb_pkg::*; #(
   parameter int NUM_IDS  = 64,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 4,
   parameter int FIXED_ON = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic [NUM_IDS-1:0] gate_en,
   output logic [NUM_IDS-1:0] gclk_out
);
   localparam int NUM_BANKS = NUM_IDS / DATA_W;
   localparam int BANK_FW   = ADDR_W - 2;
   localparam int BANK_NEED = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

   generate
      if (NUM_IDS < 1 || NUM_IDS > 64)
         $error("pclk_gate_bank: NUM_IDS must be within 1..64");
      if (NUM_IDS % DATA_W != 0)
         $error("pclk_gate_bank: NUM_IDS must be a multiple of DATA_W");
      if (BANK_FW < BANK_NEED)
         $error("pclk_gate_bank: ADDR_W too small for the bank count");
      if (FIXED_ON < 0 || FIXED_ON > NUM_IDS)
         $error("pclk_gate_bank: FIXED_ON out of range");
   endgenerate

   reg_kind_e          acc_kind;
   logic [BANK_FW-1:0] acc_bank;
   logic               wr_fire;

   assign acc_kind = reg_kind_e'(bus_addr[1:0]);
   assign acc_bank = bus_addr[ADDR_W-1:2];
   assign wr_fire  = bus_sel & bus_wr;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic              hit;
      logic [DATA_W-1:0] set_w;
      logic [DATA_W-1:0] clr_w;

      assign hit   = wr_fire && (acc_bank == BANK_FW'(b));
      assign set_w = (hit && acc_kind == REG_SET) ? bus_wdata : '0;
      assign clr_w = (hit && acc_kind == REG_CLR) ? bus_wdata : '0;

      pgb_regbank #(
         .DATA_W  (DATA_W),
         .BASE_ID (b * DATA_W),
         .FIXED_ON(FIXED_ON)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_mask(set_w),
         .clr_mask(clr_w),
         .state   (gate_en[b*DATA_W +: DATA_W])
      );
   end

   for (genvar i = 0; i < NUM_IDS; i++) begin : g_cell
      pgb_gate_cell #(
         .INIT_ON(i < FIXED_ON)
      ) u_cell (
         .clk  (clk),
         .rst_n(rst_n),
         .en   (gate_en[i]),
         .gclk (gclk_out[i])
      );
   end

   pgb_rd_mux #(
      .NUM_IDS(NUM_IDS),
      .DATA_W (DATA_W),
      .BANK_FW(BANK_FW)
   ) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_fire  (bus_sel & ~bus_wr),
      .rd_bank  (acc_bank),
      .rd_kind  (acc_kind),
      .state_all(gate_en),
      .rdata    (bus_rdata)
   );
endmodule

// File: rtl/pclk_gate_bank_chk.sv
module pclk_gate_bank_chk #(
   parameter int NUM_IDS  = 64,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 4,
   parameter int FIXED_ON = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_sel,
   input logic               bus_wr,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [DATA_W-1:0]  bus_wdata,
   input logic [DATA_W-1:0]  bus_rdata,
   input logic [NUM_IDS-1:0] gate_en,
   input logic [NUM_IDS-1:0] gclk_out
);
   localparam int NUM_BANKS = NUM_IDS / DATA_W;

   function automatic logic [NUM_IDS-1:0] fixed_all();
      logic [NUM_IDS-1:0] m;
      m = '0;
      for (int i = 0; i < NUM_IDS; i++)
         if (i < FIXED_ON) m[i] = 1'b1;
      return m;
   endfunction

   localparam logic [NUM_IDS-1:0] FIX = fixed_all();

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
      localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(4*b);
      localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(4*b + 1);
      localparam logic [ADDR_W-1:0] A_STA = ADDR_W'(4*b + 2);
      localparam logic [DATA_W-1:0] FIXB  = FIX[b*DATA_W +: DATA_W];

      assert_set_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_sel && bus_wr && bus_addr == A_SET) |=>
         ((gate_en[b*DATA_W +: DATA_W] & $past(bus_wdata)) == $past(bus_wdata)));

      assert_clr_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_sel && bus_wr && bus_addr == A_CLR) |=>
         ((gate_en[b*DATA_W +: DATA_W] & $past(bus_wdata) & ~FIXB) == '0));

      assert_zero_bits_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_sel && bus_wr && bus_addr == A_SET) |=>
         ((gate_en[b*DATA_W +: DATA_W] & ~$past(bus_wdata)) ==
          ($past(gate_en[b*DATA_W +: DATA_W]) & ~$past(bus_wdata))));

      assert_status_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_sel && !bus_wr && bus_addr == A_STA) |=>
         (bus_rdata == $past(gate_en[b*DATA_W +: DATA_W])));

      assert_ctrl_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_sel && !bus_wr && (bus_addr == A_SET || bus_addr == A_CLR)) |=>
         (bus_rdata == '0));

      assert_status_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_sel && bus_wr && bus_addr == A_STA) |=> $stable(gate_en));
   end

   if (FIXED_ON > 0) begin : g_fix
      assert_fixed_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (&gate_en[FIXED_ON-1:0]));
   end

   // Sampled just before a rising edge, the master clock is low: no gate may be high
   assert_gclk_low_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (gclk_out == '0));
endmodule

bind pclk_gate_bank pclk_gate_bank_chk #(
   .NUM_IDS (NUM_IDS),
   .DATA_W  (DATA_W),
   .ADDR_W  (ADDR_W),
   .FIXED_ON(FIXED_ON)
) u_chk (.*);

// File: tb/pclk_gate_bank_tb_top.sv
module pclk_gate_bank_tb_top;
   localparam int NV = 21;
   // {write, req, addr, data}: write=1 drives data, write=0 reads and expects data
   localparam logic [40:0] VEC [NV] = '{
      {1'b1, 4'd1, 4'h0, 32'h0000_00F0},
      {1'b0, 4'd1, 4'h2, 32'h0000_00F3},  // R1 set
      {1'b1, 4'd5, 4'h4, 32'h8000_0001},
      {1'b0, 4'd5, 4'h6, 32'h8000_0001},  // R5 bank 1 mapping
      {1'b1, 4'd2, 4'h1, 32'h0000_0030},
      {1'b0, 4'd2, 4'h2, 32'h0000_00C3},  // R2 clear
      {1'b1, 4'd3, 4'h0, 32'h0000_0000},
      {1'b0, 4'd3, 4'h2, 32'h0000_00C3},  // R3 zero bits
      {1'b1, 4'd6, 4'h1, 32'h0000_0003},
      {1'b0, 4'd6, 4'h2, 32'h0000_00C3},  // R6 fixed ids
      {1'b1, 4'd9, 4'h6, 32'h0000_1234},
      {1'b0, 4'd9, 4'h6, 32'h8000_0001},  // R9 status write
      {1'b0, 4'd8, 4'h0, 32'h0000_0000},  // R8 set reads 0
      {1'b0, 4'd8, 4'h5, 32'h0000_0000},  // R8 clear reads 0
      {1'b0, 4'd8, 4'h3, 32'h0000_0000},  // R8 reserved reads 0
      {1'b1, 4'd1, 4'h0, 32'hFFFF_FFFF},
      {1'b0, 4'd4, 4'h2, 32'hFFFF_FFFF},  // R4 status
      {1'b1, 4'd2, 4'h1, 32'hFFFF_FFFF},
      {1'b0, 4'd6, 4'h2, 32'h0000_0003},  // R6 survives clear-all
      {1'b1, 4'd2, 4'h5, 32'h8000_0000},
      {1'b0, 4'd5, 4'h6, 32'h0000_0001}   // R5 top id of bank 1
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [63:0] gate_en;
   logic [63:0] gclk_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pclk_gate_bank dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_sel  (bus_sel),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .gate_en  (gate_en),
      .gclk_out (gclk_out)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      d = bus_rdata;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 20);
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R7: reset state
      chk("R7", gate_en, 64'h0000_0000_0000_0003);
      bus_read(4'h2, rd); chk("R7", {32'h0, rd}, 64'h3);
      bus_read(4'h6, rd); chk("R7", {32'h0, rd}, 64'h0);

      for (int k = 0; k < NV; k++) begin
         if (VEC[k][40]) bus_write(VEC[k][35:32], VEC[k][31:0]);
         else begin
            bus_read(VEC[k][35:32], rd);
            chk($sformatf("R%0d vec%0d", VEC[k][39:36], k), {32'h0, rd}, {32'h0, VEC[k][31:0]});
         end
      end
      // R11: gate_en port mirrors status
      chk("R11", gate_en, 64'h0000_0001_0000_0003);

      // R10: gated clocks
      bus_write(4'h0, 32'h0000_0020);
      @(posedge clk); #5;
      chk("R10 high phase id5", {63'h0, gclk_out[5]}, 64'h1);
      chk("R10 high phase id6", {63'h0, gclk_out[6]}, 64'h0);
      chk("R10 high phase id0", {63'h0, gclk_out[0]}, 64'h1);
      @(negedge clk); #5;
      chk("R10 low phase", gclk_out, 64'h0);
      bus_write(4'h1, 32'h0000_0020);
      @(posedge clk); #5;
      chk("R10 after clear id5", {63'h0, gclk_out[5]}, 64'h0);

      // R7: reset during operation
      bus_write(4'h0, 32'h0F00_0000);
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R7 rerun", gate_en, 64'h0000_0000_0000_0003);
      bus_read(4'h2, rd); chk("R7 rerun status", {32'h0, rd}, 64'h3);
      finish_run();
   end
endmodule